// File: doc/BRIEF.md
# Synchronised Clock Fanout Gate

This block takes two reference clocks and picks one of them with a static source-select input. It drives the chosen clock onto a bank of ten output pairs. Each pair is modelled as a true logic output and a complement logic output. A clock distribution network uses it as the final gating stage in front of a group of loads that share one clock.

An active-high disable input stops the whole bank. This input may change at any moment, with no timing relation to either clock. The block passes it through a chain of flops on the rising edge of the selected clock. A register on the falling edge then turns the synchronised value into a gate. Because that register changes only at the falling edge, the gate opens and closes only while the clock is low. Every high pulse on the outputs is therefore full width. A disabled pair rests with its true output low and its complement output high. Disable and enable each take effect within a fixed window of about one clock period.

Top module: `clk_fanout_gate`

## Requirements
- R1: With `src_sel` = 0, every true output toggles with the period of `clk_a`.
- R2: With `src_sel` = 1, every true output toggles with the period of `clk_b`.
- R3: While enabled, all ten true outputs are equal to each other at every moment, and each complement output is the inverse of its true output.
- R4: After the synchronous reset `rst` is released with `out_dis` = 0, the outputs toggle without any further stimulus.
- R5: While disabled, every true output is held at 0 and every complement output is held at 1.
- R6: No high pulse on a true output is shorter than half a period of the selected clock, even when `out_dis` changes at an arbitrary phase.
- R7: After `out_dis` rises, the last falling edge of the true outputs comes between 2.5 and 3.5 selected-clock periods later.
- R8: After `out_dis` falls, the first rising edge of the true outputs comes between 3 and 4 selected-clock periods later.
- R9: The internal gate changes state only while the selected clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Reference clock used when `src_sel` = 0 |
| clk_b | input | 1 | Reference clock used when `src_sel` = 1 |
| src_sel | input | 1 | Static source select (0 = `clk_a`, 1 = `clk_b`) |
| out_dis | input | 1 | Asynchronous output disable, active high |
| rst | input | 1 | Synchronous reset, active high, sampled on the selected clock |
| q_true | output | 10 | True outputs of the ten pairs |
| q_comp | output | 10 | Complement outputs of the ten pairs |

## Verification
A wrong synchroniser depth moves a latency outside its window. This shows on the first disable or enable edge, within four periods of the command. A gate register clocked on the wrong edge, or a wrong gate polarity, cuts a high pulse short. It can also leave the bank running while `out_dis` is high. The pulse-width monitor catches the first case, and the resting-level samples taken one settle time after the command catch the second. A wrong mux or pair-wiring fault changes the measured period, or breaks the equality between pairs, as soon as the outputs run after reset.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  localparam int unsigned DEF_PAIRS  = 10;
  localparam int unsigned DEF_STAGES = 3;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_e;
endpackage

// File: rtl/clkfan_src_mux.sv
module clkfan_src_mux
  import clkfan_pkg::*;
(
  input  logic clk_a,
  input  logic clk_b,
  input  logic src_sel,
  output logic clk_o
);
  src_e src;

  assign src   = src_e'(src_sel);
  assign clk_o = (src == SRC_B) ? clk_b : clk_a;
endmodule

// File: rtl/clkfan_dis_sync.sv
module clkfan_dis_sync #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic dis_async,
  output logic dis_sync
);
  localparam int unsigned MSB = STAGES - 1;

  logic [MSB:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= dis_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dis_sync = chain[MSB];
endmodule

// File: rtl/clkfan_low_gate.sv
module clkfan_low_gate (
  input  logic clk,
  input  logic rst,
  input  logic dis_sync,
  output logic gate_en
);
  always_ff @(negedge clk) begin
    if (rst) gate_en <= 1'b1;
    else     gate_en <= ~dis_sync;
  end

  p_gate_close_r7: assert property (@(negedge clk) disable iff (rst)
    $rose(dis_sync) |=> !gate_en)
    else $error("gate did not close after synchronised disable");

  p_gate_open_r8: assert property (@(negedge clk) disable iff (rst)
    $fell(dis_sync) |=> gate_en)
    else $error("gate did not open after synchronised enable");
endmodule

// File: rtl/clkfan_out_bank.sv
module clkfan_out_bank #(
  parameter int unsigned PAIRS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_en,
  output logic [PAIRS-1:0] q_true,
  output logic [PAIRS-1:0] q_comp
);
  generate
    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
      logic drive;
      assign drive     = clk & gate_en;
      assign q_true[i] = drive;
      assign q_comp[i] = ~drive;
    end
  endgenerate

  p_dis_state_r5: assert property (@(negedge clk) disable iff (rst)
    !gate_en |-> (q_true == '0 && q_comp == '1))
    else $error("disabled bank not at rest level");
endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate
  import clkfan_pkg::*;
#(
  parameter int unsigned PAIRS  = DEF_PAIRS,
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             src_sel,
  input  logic             out_dis,
  input  logic             rst,
  output logic [PAIRS-1:0] q_true,
  output logic [PAIRS-1:0] q_comp
);
  logic clk_sel;
  logic dis_sync;
  logic gate_en;

  clkfan_src_mux u_mux (
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .src_sel (src_sel),
    .clk_o   (clk_sel)
  );

  clkfan_dis_sync #(.STAGES(STAGES)) u_sync (
    .clk       (clk_sel),
    .rst       (rst),
    .dis_async (out_dis),
    .dis_sync  (dis_sync)
  );

  clkfan_low_gate u_gate (
    .clk      (clk_sel),
    .rst      (rst),
    .dis_sync (dis_sync),
    .gate_en  (gate_en)
  );

  clkfan_out_bank #(.PAIRS(PAIRS)) u_bank (
    .clk     (clk_sel),
    .rst     (rst),
    .gate_en (gate_en),
    .q_true  (q_true),
    .q_comp  (q_comp)
  );

  p_reset_r4: assert property (@(posedge clk_sel)
    rst |=> !dis_sync)
    else $error("synchroniser not cleared by reset");

  // R3 and R9: the gate is sampled while the clock is high, and at that time it must be passed through to all pairs.
  p_run_r3: assert property (@(negedge clk_sel) disable iff (rst)
    gate_en |-> (q_true == '1 && q_comp == '0))
    else $error("enabled bank not carrying the clock high phase");
endmodule

// File: tb/tb_clk_fanout_gate.sv
`timescale 1ns/1ps
module tb_clk_fanout_gate;
  localparam int  NP = 10;
  localparam real TA = 4.0;
  localparam real TB = 6.0;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic src_sel = 1'b0;
  logic out_dis = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] q_true;
  logic [NP-1:0] q_comp;

  int n_chk = 0;
  int n_bad = 0;

  real per = TA;
  real t_cmd = 0.0;
  real first_rise = 0.0;
  real last_fall = 0.0;
  real pulse_start = -1.0;
  bit  arm_rise = 1'b0;
  int  runt_cnt = 0;

  always #(TA/2) clk_a = ~clk_a;
  always #(TB/2) clk_b = ~clk_b;

  clk_fanout_gate dut (
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .src_sel (src_sel),
    .out_dis (out_dis),
    .rst     (rst),
    .q_true  (q_true),
    .q_comp  (q_comp)
  );

  always @(posedge q_true[0]) begin
    if (arm_rise) begin
      first_rise = $realtime;
      arm_rise = 1'b0;
    end
    pulse_start = $realtime;
  end

  always @(negedge q_true[0]) begin
    last_fall = $realtime;
    if (pulse_start >= 0.0 && ($realtime - pulse_start) < per/2.0 - 0.001)
      runt_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic wait_pos();
    if (src_sel) @(posedge clk_b);
    else         @(posedge clk_a);
  endtask

  task automatic check_pairs(input bit hi, input string req);
    logic [NP-1:0] et;
    et = hi ? '1 : '0;
    chk(q_true == et && q_comp == ~et, req,
        $sformatf("t=%b c=%b", q_true, q_comp),
        $sformatf("t=%b c=%b", et, ~et));
  endtask

  task automatic run_source(input bit s);
    real t1, t2, off, lat;
    src_sel = s;
    per = s ? TB : TA;
    rst = 1'b1;
    out_dis = 1'b0;
    repeat (6) wait_pos();
    #(per/4) rst = 1'b0;
    repeat (3) wait_pos();
    runt_cnt = 0;
    pulse_start = -1.0;
    // R4, R1/R2: running after reset, period of the chosen source
    @(posedge q_true[0]); t1 = $realtime;
    @(posedge q_true[0]); t2 = $realtime;
    chk((t2 - t1) > per - 0.001 && (t2 - t1) < per + 0.001, s ? "R2/R4" : "R1/R4",
        $sformatf("%0.3f", t2 - t1), $sformatf("%0.3f", per));
    // R3: pairs equal and complementary in both phases
    #(per/4);  check_pairs(1'b1, "R3");
    #(per/2);  check_pairs(1'b0, "R3");
    for (int k = 0; k < 12; k++) begin
      off = per * (0.05 + 0.9 * ((k * 0.618) - $floor(k * 0.618)));
      wait_pos();
      #(off);
      out_dis = 1'b1;
      t_cmd = $realtime;
      #(5.0 * per);
      lat = last_fall - t_cmd;
      chk(lat > 2.5*per - 0.001 && lat < 3.5*per + 0.001, "R7",
          $sformatf("%0.3f", lat), $sformatf("[%0.3f,%0.3f]", 2.5*per, 3.5*per));
      for (int j = 0; j < 3; j++) begin
        #(per/3);
        check_pairs(1'b0, "R5");
      end
      off = per * (0.95 - 0.9 * ((k * 0.382) - $floor(k * 0.382)));
      wait_pos();
      #(off);
      out_dis = 1'b0;
      t_cmd = $realtime;
      first_rise = -1.0;
      arm_rise = 1'b1;
      #(5.0 * per);
      lat = first_rise - t_cmd;
      chk(!arm_rise && lat > 3.0*per - 0.001 && lat < 4.0*per + 0.001, "R8",
          $sformatf("%0.3f", lat), $sformatf("[%0.3f,%0.3f]", 3.0*per, 4.0*per));
    end
    // R6 and R9: no shortened high pulse across all random-phase changes
    chk(runt_cnt == 0, "R6/R9", $sformatf("%0d", runt_cnt), "0");
  endtask

  initial begin
    #(10.3);
    run_source(1'b0);
    run_source(1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000.0 * TA);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule